// File: doc/BRIEF.md
# Staggered Cell-Enable Sequencer for a Segmented Bus Driver

This block drives the digital enables of a bus output stage that is built from N identical unit cells instead of one large transistor. When the transmit bit changes, the cells are not switched together: a shift chain clocked by a selectable step rate turns them on or off one at a time. The current drawn from the supply therefore ramps in N small steps rather than as one surge. The spacing between steps is picked from eight rates, each a power of two of the reference clock.

An optional matching stage rotates the assignment of logical enable slots to physical cells, with an offset drawn from a linear feedback shift register. Mismatch between cells is therefore averaged over many edges instead of always showing up in the same order. The offset is only allowed to change while every slot holds the same value, so a ramp in progress never changes shape. A two-bit trim input selects one of four size options that is applied to every cell and delivered as a one-hot code.

Top module: `seg_drive_seq`

## Requirements
- R1: While rst_n is low, and just after it rises, every bit of cell_en is 0 and cell_opt is 4'b0001.
- R2: With step_sel = k (0 to 7), the logical enable chain advances exactly once every 2^k clock cycles, so successive changes of cell_en during a ramp are exactly 2^k cycles apart.
- R3: On each step, logical slot 0 takes the current txd value and slot i takes the previous value of slot i-1.
- R4: With matching off, a txd rise held long enough gives cell_en = 0x01, 0x03, 0x07 ... 0xFF (cell 0 first). A fall gives 0xFE, 0xFC ... 0x00 (cell 0 first off).
- R5: Once txd is held for N steps, all cells are on (txd high) or all are off (txd low). The number of enabled cells never changes by more than one between consecutive clock cycles.
- R6: With dem_en high, cell_en is the logical pattern rotated by an offset taken from the pseudo-random generator. It keeps the same number of set bits, the set bits are contiguous around the ring, and the first cell to switch on differs between ramps.
- R7: The rotation offset, including the one that results from a change of dem_en, is updated only while all logical slots are equal. A dem_en change in the middle of a ramp leaves the rest of that ramp unchanged.
- R8: With dem_en low at the last moment all slots were equal, the mapping is identity (cell j follows slot j).
- R9: One cycle after trim_sel = s is applied, cell_opt has only bit s set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| txd | input | 1 | Transmit bit to be ramped onto the cells |
| step_sel | input | 3 | Step rate select, step period 2^step_sel cycles |
| dem_en | input | 1 | Enable rotation of slot-to-cell mapping |
| trim_sel | input | 2 | Cell size option select |
| cell_en | output | 8 | Per physical cell enable |
| cell_opt | output | 4 | One-hot size option applied to all cells |

## Verification
Two functions can coincide: a step of the chain and a change of the rotation offset. Both are provoked together by raising dem_en partway through a rising ramp. The scoreboard still expects the identity staircase for the rest of that ramp, which shows that the new offset waits until all slots are equal. The ramps that follow are judged on set-bit count, ring contiguity and exact step spacing. A separate check requires the first cell switched on to vary across ramps.

// File: rtl/seg_drv_pkg.sv
package seg_drv_pkg;

    localparam int OPT_W = 4;

    function automatic logic [OPT_W-1:0] opt_decode(input logic [1:0] sel);
        return OPT_W'(1) << sel;
    endfunction

endpackage

// File: rtl/step_tick_gen.sv
module step_tick_gen #(
    parameter int SEL_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SEL_W-1:0] step_sel,
    output logic             tick
);
    localparam int LEVELS = 1 << SEL_W;
    localparam int CNT_W  = (LEVELS > 1) ? LEVELS - 1 : 1;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } div_st_t;

    div_st_t st_d, st_q;
    logic [LEVELS-1:0] sel_oh;
    logic [LEVELS-1:0] tap;

    // Level k fires once every 2^k cycles: low k counter bits all ones.
    for (genvar k = 0; k < LEVELS; k++) begin : g_tap
        if (k == 0) begin : g_base
            assign tap[k] = 1'b1;
        end else begin : g_div
            assign tap[k] = &st_q.cnt[k-1:0];
        end
    end

    always_comb begin
        sel_oh    = LEVELS'(1) << step_sel;
        tick      = |(sel_oh & tap);
        st_d      = st_q;
        st_d.cnt  = st_q.cnt + CNT_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

endmodule

// File: rtl/stagger_chain.sv
module stagger_chain #(
    parameter int CELLS = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             txd,
    output logic [CELLS-1:0] slots
);
    typedef struct packed {
        logic [CELLS-1:0] sh;
    } chain_st_t;

    chain_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (tick) st_d.sh = {st_q.sh[CELLS-2:0], txd};
        slots = st_q.sh;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R3: slot 0 captures txd on a step
    p_shift_head_r3: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> slots[0] == $past(txd));

    // R3: slot i follows slot i-1 on a step
    p_shift_body_r3: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> slots[CELLS-1:1] == $past(slots[CELLS-2:0]));

    // R2: no movement between steps
    p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(slots));

endmodule

// File: rtl/dem_router.sv
module dem_router #(
    parameter int              CELLS  = 8,
    parameter int              LFSR_W = 16,
    parameter logic [LFSR_W-1:0] TAPS = 16'hB400,
    parameter logic [LFSR_W-1:0] SEED = 16'hACE1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             dem_en,
    input  logic [CELLS-1:0] slots,
    output logic [CELLS-1:0] phys
);
    localparam int ROT_W = (CELLS > 1) ? $clog2(CELLS) : 1;

    typedef struct packed {
        logic [LFSR_W-1:0] lfsr;
        logic [ROT_W-1:0]  rot;
    } dem_st_t;

    dem_st_t st_d, st_q;
    logic    uniform;
    int      src;

    always_comb begin
        uniform = (&slots) | ~(|slots);
        st_d    = st_q;
        // Galois step every cycle
        st_d.lfsr = st_q.lfsr >> 1;
        if (st_q.lfsr[0]) st_d.lfsr = (st_q.lfsr >> 1) ^ TAPS;
        // Mapping may only move while all slots agree
        if (uniform) begin
            if (dem_en) st_d.rot = ROT_W'(int'(st_q.lfsr) % CELLS);
            else        st_d.rot = '0;
        end
    end

    // Rotation mux array: physical cell j takes slot (j - rot) mod CELLS
    always_comb begin
        phys = '0;
        src  = 0;
        for (int j = 0; j < CELLS; j++) begin
            src     = (j + CELLS - int'(st_q.rot)) % CELLS;
            phys[j] = slots[src];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.lfsr <= SEED;
            st_q.rot  <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // R7: offset frozen while a ramp is in progress
    p_map_frozen_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !uniform |=> $stable(st_q.rot));

    // R6: routing keeps the number of active cells
    p_count_kept_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(phys) == $countones(slots));

endmodule

// File: rtl/seg_drive_seq.sv
module seg_drive_seq #(
    parameter int CELLS     = 8,
    parameter int SEL_W     = 3,
    parameter int LFSR_W    = 16,
    parameter logic [LFSR_W-1:0] LFSR_TAPS = 16'hB400,
    parameter logic [LFSR_W-1:0] LFSR_SEED = 16'hACE1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             txd,
    input  logic [SEL_W-1:0] step_sel,
    input  logic             dem_en,
    input  logic [1:0]       trim_sel,
    output logic [CELLS-1:0] cell_en,
    output logic [seg_drv_pkg::OPT_W-1:0] cell_opt
);
    import seg_drv_pkg::*;

    typedef struct packed {
        logic [OPT_W-1:0] opt;
    } top_st_t;

    top_st_t          st_d, st_q;
    logic             step_tick;
    logic [CELLS-1:0] slots;

    step_tick_gen #(.SEL_W(SEL_W)) u_tick (
        .clk      (clk),
        .rst_n    (rst_n),
        .step_sel (step_sel),
        .tick     (step_tick)
    );

    stagger_chain #(.CELLS(CELLS)) u_chain (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (step_tick),
        .txd   (txd),
        .slots (slots)
    );

    dem_router #(
        .CELLS  (CELLS),
        .LFSR_W (LFSR_W),
        .TAPS   (LFSR_TAPS),
        .SEED   (LFSR_SEED)
    ) u_dem (
        .clk    (clk),
        .rst_n  (rst_n),
        .dem_en (dem_en),
        .slots  (slots),
        .phys   (cell_en)
    );

    always_comb begin
        st_d     = st_q;
        st_d.opt = opt_decode(trim_sel);
        cell_opt = st_q.opt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q.opt <= OPT_W'(1);
        else        st_q     <= st_d;
    end

    // R5: at most one cell joins or leaves per cycle
    p_one_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(cell_en) <= $countones($past(cell_en)) + 1) &&
        ($countones(cell_en) + 1 >= $countones($past(cell_en))));

    // R5: full slot pattern means every physical cell driven
    p_full_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (&slots) |-> (&cell_en));

    // R9: option code is one-hot and follows the select
    p_opt_onehot_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot(cell_opt));
    p_opt_track_r9: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> cell_opt[$past(trim_sel)]);

endmodule

// File: tb/seg_drive_seq_tb_top.sv
module seg_drive_seq_tb_top;
    localparam int N = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       txd = 1'b0;
    logic [2:0] step_sel = '0;
    logic       dem_en = 1'b0;
    logic [1:0] trim_sel = '0;
    logic [N-1:0] cell_en;
    logic [3:0]   cell_opt;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    typedef struct {
        logic [N-1:0] pat;
        int           cnt;
        bit           dem;
        int           gap;
        bit           rise;
    } exp_t;

    exp_t exp_q[$];
    logic [N-1:0] prev;
    int           since = 0;
    logic [N-1:0] first_seen = '0;
    bit           mon_on = 0;

    always #5 clk = ~clk;

    seg_drive_seq dut_i (
        .clk(clk), .rst_n(rst_n), .txd(txd), .step_sel(step_sel),
        .dem_en(dem_en), .trim_sel(trim_sel),
        .cell_en(cell_en), .cell_opt(cell_opt)
    );

    function automatic logic [N-1:0] thermo(input int m);
        logic [N:0] t;
        t = (N+1)'(1) << m;
        return N'(t - 1);
    endfunction

    function automatic bit ring_contig(input logic [N-1:0] v);
        int edges = 0;
        for (int j = 0; j < N; j++)
            if (v[j] && !v[(j + N - 1) % N]) edges++;
        return edges <= 1;
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp_v);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp_v);
        end
    endtask

    // Monitor: pops one expected item per change of cell_en
    always @(negedge clk) begin
        if (mon_on) begin
            since++;
            if (cell_en !== prev) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R5 unexpected change", int'(cell_en), int'(prev));
                end else begin
                    exp_t it;
                    it = exp_q.pop_front();
                    if (!it.dem) begin
                        chk(cell_en === it.pat, "R4/R8 staircase", int'(cell_en), int'(it.pat));
                    end else begin
                        chk($countones(cell_en) == it.cnt, "R6 count", $countones(cell_en), it.cnt);
                        chk(ring_contig(cell_en), "R6 contiguity", int'(cell_en), 1);
                        if (it.rise && it.cnt == 1) first_seen |= cell_en;
                    end
                    if (it.gap >= 0)
                        chk(since == it.gap, "R2 step spacing", since, it.gap);
                end
                since = 0;
            end
            prev = cell_en;
        end
    end

    // Driver: queue the expected staircase, then move txd
    task automatic do_ramp(input bit lvl, input int k, input bit dem_mode,
                           input int idle, input int sw_at);
        repeat (idle) @(negedge clk);
        step_sel = 3'(k);
        for (int m = 1; m <= N; m++) begin
            exp_t it;
            it.cnt  = lvl ? m : N - m;
            it.pat  = lvl ? thermo(m) : ~thermo(m);
            it.dem  = dem_mode;
            it.gap  = (m == 1) ? -1 : (1 << k);
            it.rise = lvl;
            exp_q.push_back(it);
        end
        @(negedge clk);
        txd = lvl;
        if (sw_at >= 0) begin
            while (exp_q.size() > N - sw_at) @(negedge clk);
            dem_en = 1'b1;   // mid-ramp request, R7
        end
        while (exp_q.size() > 0) @(negedge clk);
        repeat (3) @(negedge clk);
        chk(cell_en === (lvl ? {N{1'b1}} : {N{1'b0}}), "R5 final level",
            int'(cell_en), lvl ? (1 << N) - 1 : 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(cell_en === '0, "R1 enables in reset", int'(cell_en), 0);
        chk(cell_opt === 4'b0001, "R1 option in reset", int'(cell_opt), 1);
        rst_n = 1'b1;
        @(negedge clk);
        chk(cell_en === '0, "R1 enables after reset", int'(cell_en), 0);
        chk(cell_opt === 4'b0001, "R1 option after reset", int'(cell_opt), 1);

        for (int s = 3; s >= 0; s--) begin
            trim_sel = 2'(s);
            @(negedge clk);
            chk(cell_opt === (4'b0001 << s), "R9 option decode", int'(cell_opt), 1 << s);
        end

        prev = cell_en;
        mon_on = 1;

        // R3/R4 identity staircases at several step rates (R2)
        do_ramp(1, 0, 0, 2, -1);
        do_ramp(0, 0, 0, 4, -1);
        do_ramp(1, 1, 0, 5, -1);
        do_ramp(0, 3, 0, 3, -1);
        do_ramp(1, 7, 0, 9, -1);
        do_ramp(0, 2, 0, 6, -1);

        // R7: matching requested after three steps; ramp stays identity
        do_ramp(1, 2, 0, 4, 3);

        // R6: rotated ramps with varying idle gaps
        do_ramp(0, 1, 1, 5, -1);
        do_ramp(1, 0, 1, 7, -1);
        do_ramp(0, 1, 1, 11, -1);
        do_ramp(1, 2, 1, 13, -1);
        do_ramp(0, 0, 1, 17, -1);
        do_ramp(1, 1, 1, 23, -1);
        do_ramp(0, 0, 1, 29, -1);
        do_ramp(1, 3, 1, 31, -1);
        do_ramp(0, 0, 1, 37, -1);
        chk($countones(first_seen) >= 2, "R6 first cell varies",
            int'(first_seen), 2);

        // R8: matching off while uniform gives identity again
        @(negedge clk);
        dem_en = 1'b0;
        do_ramp(1, 0, 0, 4, -1);
        do_ramp(0, 1, 0, 4, -1);

        trim_sel = 2'd2;
        @(negedge clk);
        chk(cell_opt === 4'b0100, "R9 option while idle", int'(cell_opt), 4);

        mon_on = 0;
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule